// File: doc/BRIEF.md
# Console Character I/O Controller

This block serves two console devices on the CPU's I/O instruction bus: a keyboard receiver and a text display transmitter. On every cycle with `io_valid` high, the block decodes an 8-bit device code and a 4-bit operation code. From them it computes the new accumulator value, a clear-accumulator strobe and a skip request, all combinationally. Its internal flags and buffers take their new values on the next clock edge.

The keyboard side holds the last received character and a done flag. It fetches one character at a time from an input stream through a valid/ready handshake. The display side holds the character to transmit and its own done flag. It offers that character on an output stream until the sink accepts it. Only the 8-bit ASCII arrangement is built. A received character always reads back with bit 7 set, and bit 7 of a transmitted character is forced to zero. One display operation tests both done flags at once, so a program can wait on either side with a single skip.

Top module: `chario_console`

## Requirements
- R1: The keyboard answers device code 0x03 and the display answers 0x04. When `io_valid` is low, or the device code or the operation code is not one listed here, `acc_out` equals `acc_in`, `skip` and `acc_clr` are 0, and no flag, buffer or transfer changes.
- R2: Keyboard op 0 clears the keyboard flag. Keyboard op 1 drives `skip` to the value of the keyboard flag.
- R3: Keyboard op 2 drives `acc_out` to zero and raises `acc_clr`. It clears the keyboard flag and starts a fetch, so `kin_ready` is high from the next cycle until a character is taken.
- R4: A character is taken on a cycle where `kin_valid` and `kin_ready` are both high. Its bits 6:0 are stored, the keyboard flag is 1 from the next cycle, and `kin_ready` falls.
- R5: Keyboard op 4 drives `acc_out` to `acc_in` OR the keyboard value and leaves the keyboard flag unchanged.
- R6: Keyboard op 6 drives `acc_out` to the keyboard value zero-extended to the accumulator width and raises `acc_clr`. It also clears the keyboard flag and starts a fetch.
- R7: The keyboard value is the stored bits 6:0 with bit 7 forced to 1, whatever bit 7 of the received character was. `tout_data` bit 7 is always 0.
- R8: Display op 0 sets the display flag, op 2 clears it, and op 1 drives `skip` to its value.
- R9: Display op 4 stores `acc_in[7:0]` and raises `tout_valid` from the next cycle, with `tout_data` = {0, `acc_in[6:0]`}. Data and valid hold until `tout_ready` is high. The display flag is 1 from the cycle after that handshake, and op 4 leaves it unchanged otherwise.
- R10: Display op 6 behaves as op 4 but clears the display flag.
- R11: Display op 5 drives `skip` to the OR of the display flag and the keyboard flag.
- R12: In one cycle, a completed handshake overrides a plain flag clear (keyboard op 0, display op 2). An operation that clears a flag and starts a transfer (keyboard ops 2 and 6, display op 6) overrides a completed handshake, which then ends the earlier transfer.
- R13: Reset clears both flags, both buffers and both transfers. After reset, keyboard op 4 with a zero accumulator returns 0x080.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | An I/O instruction is present this cycle |
| io_dev | input | 8 | Device code |
| io_op | input | 4 | Device operation code |
| acc_in | input | ACC_W | Accumulator before the instruction |
| acc_out | output | ACC_W | Accumulator after the instruction |
| acc_clr | output | 1 | The instruction replaced the accumulator contents |
| skip | output | 1 | Skip the next instruction |
| kin_valid | input | 1 | Input stream offers a character |
| kin_data | input | 8 | Input stream character |
| kin_ready | output | 1 | A keyboard fetch is pending |
| tout_valid | output | 1 | Output stream character available |
| tout_data | output | 8 | Output stream character, bit 7 zero |
| tout_ready | input | 1 | Output stream accepts the character |

## Verification
The bench builds the block with ACC_W = 12 and the default device codes 0x03 and 0x04. The accumulator is therefore wider than a character. That exposes both the zeroing of the upper bits on keyboard op 6 and the preservation of the upper bits on keyboard op 4. Neighbouring codes 0x05, op 3 and op 7 are used to probe that unknown instructions are ignored. Directed sequences, with the handshake timing held back and then released, cover the same-cycle overlaps between a handshake and a flag-clearing operation. A long mixed run covers the remaining combinations.

// File: rtl/chario_pkg.sv
package chario_pkg;

    localparam int CHAR_W = 8;
    localparam int CODE_W = CHAR_W - 1;
    localparam int DEV_W  = 8;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        KOP_DROP      = 4'd0,
        KOP_TEST      = 4'd1,
        KOP_ZERO_GET  = 4'd2,
        KOP_MERGE     = 4'd4,
        KOP_TAKE_GET  = 4'd6
    } kbd_op_e;

    typedef enum logic [OP_W-1:0] {
        DOP_RAISE     = 4'd0,
        DOP_TEST      = 4'd1,
        DOP_DROP      = 4'd2,
        DOP_SEND      = 4'd4,
        DOP_TEST_ANY  = 4'd5,
        DOP_FRESH     = 4'd6
    } dsp_op_e;

    // actions consumed by the keyboard channel
    typedef struct packed {
        logic drop_flag;
        logic fetch;
    } kbd_ctl_t;

    // actions consumed by the display channel
    typedef struct packed {
        logic raise_flag;
        logic drop_flag;
        logic send;
        logic fresh;
    } dsp_ctl_t;

    // actions consumed by the result path
    typedef struct packed {
        logic test_k;
        logic test_d;
        logic test_either;
        logic zero_acc;
        logic merge_acc;
        logic take_acc;
    } res_ctl_t;

    function automatic logic [CHAR_W-1:0] kbd_view(input logic [CODE_W-1:0] code);
        return {1'b1, code};
    endfunction

    function automatic logic [CHAR_W-1:0] tx_view(input logic [CODE_W-1:0] code);
        return {1'b0, code};
    endfunction

endpackage

// File: rtl/chario_decode.sv
module chario_decode
    import chario_pkg::*;
#(
    parameter logic [DEV_W-1:0] KBD_DEV = 8'h03,
    parameter logic [DEV_W-1:0] DSP_DEV = 8'h04
) (
    input  logic             io_valid,
    input  logic [DEV_W-1:0] io_dev,
    input  logic [OP_W-1:0]  io_op,
    output kbd_ctl_t         kbd_ctl,
    output dsp_ctl_t         dsp_ctl,
    output res_ctl_t         res_ctl
);

    logic hit_kbd;
    logic hit_dsp;

    assign hit_kbd = io_valid && (io_dev == KBD_DEV);
    assign hit_dsp = io_valid && (io_dev == DSP_DEV);

    always_comb begin
        kbd_ctl = '0;
        dsp_ctl = '0;
        res_ctl = '0;
        if (hit_kbd) begin
            case (io_op)
                KOP_DROP:     kbd_ctl.drop_flag = 1'b1;
                KOP_TEST:     res_ctl.test_k    = 1'b1;
                KOP_ZERO_GET: begin
                    kbd_ctl.fetch    = 1'b1;
                    res_ctl.zero_acc = 1'b1;
                end
                KOP_MERGE:    res_ctl.merge_acc = 1'b1;
                KOP_TAKE_GET: begin
                    kbd_ctl.fetch    = 1'b1;
                    res_ctl.take_acc = 1'b1;
                end
                default: ;
            endcase
        end
        if (hit_dsp) begin
            case (io_op)
                DOP_RAISE:    dsp_ctl.raise_flag  = 1'b1;
                DOP_TEST:     res_ctl.test_d      = 1'b1;
                DOP_DROP:     dsp_ctl.drop_flag   = 1'b1;
                DOP_SEND:     dsp_ctl.send        = 1'b1;
                DOP_TEST_ANY: res_ctl.test_either = 1'b1;
                DOP_FRESH: begin
                    dsp_ctl.send  = 1'b1;
                    dsp_ctl.fresh = 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/chario_kbd.sv
module chario_kbd
    import chario_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  kbd_ctl_t          ctl,
    input  logic              kin_valid,
    input  logic [CODE_W-1:0] kin_code,
    output logic              kin_ready,
    output logic              flag,
    output logic [CHAR_W-1:0] view
);

    logic [CODE_W-1:0] code_q;
    logic              flag_q;
    logic              busy_q;
    logic              taken;

    assign taken = busy_q & kin_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            flag_q <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            if (taken) begin
                code_q <= kin_code;
            end
            busy_q <= ctl.fetch | (busy_q & ~taken);
            flag_q <= ~ctl.fetch & (taken | (flag_q & ~ctl.drop_flag));
        end
    end

    assign kin_ready = busy_q;
    assign flag      = flag_q;
    assign view      = kbd_view(code_q);

endmodule

// File: rtl/chario_disp.sv
module chario_disp
    import chario_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  dsp_ctl_t          ctl,
    input  logic [CODE_W-1:0] acc_code,
    input  logic              tout_ready,
    output logic              tout_valid,
    output logic [CHAR_W-1:0] tout_data,
    output logic              flag
);

    logic [CODE_W-1:0] code_q;
    logic              flag_q;
    logic              busy_q;
    logic              accepted;

    assign accepted = busy_q & tout_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            flag_q <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            if (ctl.send) begin
                code_q <= acc_code;
            end
            busy_q <= ctl.send | (busy_q & ~accepted);
            flag_q <= ~ctl.fresh &
                      (ctl.raise_flag | accepted | (flag_q & ~ctl.drop_flag));
        end
    end

    assign tout_valid = busy_q;
    assign tout_data  = tx_view(code_q);
    assign flag       = flag_q;

endmodule

// File: rtl/chario_result.sv
module chario_result
    import chario_pkg::*;
#(
    parameter int ACC_W = 12
) (
    input  res_ctl_t          ctl,
    input  logic [ACC_W-1:0]  acc_in,
    input  logic [CHAR_W-1:0] kview,
    input  logic              kflag,
    input  logic              dflag,
    output logic [ACC_W-1:0]  acc_out,
    output logic              acc_clr,
    output logic              skip
);

    logic [ACC_W-1:0] kwide;

    assign kwide = ACC_W'(kview);

    always_comb begin
        if (ctl.take_acc) begin
            acc_out = kwide;
        end else if (ctl.zero_acc) begin
            acc_out = '0;
        end else if (ctl.merge_acc) begin
            acc_out = acc_in | kwide;
        end else begin
            acc_out = acc_in;
        end
    end

    assign acc_clr = ctl.take_acc | ctl.zero_acc;
    assign skip    = (ctl.test_k & kflag) | (ctl.test_d & dflag) |
                     (ctl.test_either & (kflag | dflag));

endmodule

// File: rtl/chario_console.sv
module chario_console
    import chario_pkg::*;
#(
    parameter int               ACC_W   = 12,
    parameter logic [DEV_W-1:0] KBD_DEV = 8'h03,
    parameter logic [DEV_W-1:0] DSP_DEV = 8'h04
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              io_valid,
    input  logic [DEV_W-1:0]  io_dev,
    input  logic [OP_W-1:0]   io_op,
    input  logic [ACC_W-1:0]  acc_in,
    output logic [ACC_W-1:0]  acc_out,
    output logic              acc_clr,
    output logic              skip,
    input  logic              kin_valid,
    input  logic [CHAR_W-1:0] kin_data,
    output logic              kin_ready,
    output logic              tout_valid,
    output logic [CHAR_W-1:0] tout_data,
    input  logic              tout_ready
);

    kbd_ctl_t          kbd_ctl;
    dsp_ctl_t          dsp_ctl;
    res_ctl_t          res_ctl;
    logic              kb_flag;
    logic              dp_flag;
    logic [CHAR_W-1:0] kb_view;
    logic              unused_kin_msb;

    assign unused_kin_msb = kin_data[CHAR_W-1];

    chario_decode #(
        .KBD_DEV (KBD_DEV),
        .DSP_DEV (DSP_DEV)
    ) u_decode (
        .io_valid (io_valid),
        .io_dev   (io_dev),
        .io_op    (io_op),
        .kbd_ctl  (kbd_ctl),
        .dsp_ctl  (dsp_ctl),
        .res_ctl  (res_ctl)
    );

    chario_kbd u_kbd (
        .clk       (clk),
        .rst       (rst),
        .ctl       (kbd_ctl),
        .kin_valid (kin_valid),
        .kin_code  (kin_data[CODE_W-1:0]),
        .kin_ready (kin_ready),
        .flag      (kb_flag),
        .view      (kb_view)
    );

    chario_disp u_disp (
        .clk        (clk),
        .rst        (rst),
        .ctl        (dsp_ctl),
        .acc_code   (acc_in[CODE_W-1:0]),
        .tout_ready (tout_ready),
        .tout_valid (tout_valid),
        .tout_data  (tout_data),
        .flag       (dp_flag)
    );

    chario_result #(
        .ACC_W (ACC_W)
    ) u_result (
        .ctl     (res_ctl),
        .acc_in  (acc_in),
        .kview   (kb_view),
        .kflag   (kb_flag),
        .dflag   (dp_flag),
        .acc_out (acc_out),
        .acc_clr (acc_clr),
        .skip    (skip)
    );

endmodule

// File: rtl/chario_console_chk.sv
module chario_console_chk
    import chario_pkg::*;
#(
    parameter int               ACC_W   = 12,
    parameter logic [DEV_W-1:0] KBD_DEV = 8'h03,
    parameter logic [DEV_W-1:0] DSP_DEV = 8'h04
) (
    input logic              clk,
    input logic              rst,
    input logic              io_valid,
    input logic [DEV_W-1:0]  io_dev,
    input logic [OP_W-1:0]   io_op,
    input logic [ACC_W-1:0]  acc_in,
    input logic [ACC_W-1:0]  acc_out,
    input logic              acc_clr,
    input logic              skip,
    input logic              kin_valid,
    input logic              kin_ready,
    input logic              tout_valid,
    input logic [CHAR_W-1:0] tout_data,
    input logic              tout_ready,
    input logic              kflag,
    input logic              dflag
);

    logic kbd_restart;
    logic dsp_restart;

    assign kbd_restart = io_valid && io_dev == KBD_DEV && (io_op == 4'd2 || io_op == 4'd6);
    assign dsp_restart = io_valid && io_dev == DSP_DEV && (io_op == 4'd4 || io_op == 4'd6);

    // R1
    idle_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !io_valid |-> (acc_out == acc_in && !skip && !acc_clr));

    // R4
    kin_take_chk: assert property (@(posedge clk) disable iff (rst)
        (kin_valid && kin_ready && !kbd_restart) |=> (kflag && !kin_ready));

    // R7
    tout_msb_chk: assert property (@(posedge clk) disable iff (rst)
        tout_valid |-> !tout_data[CHAR_W-1]);

    // R9
    tout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tout_valid && !tout_ready && !dsp_restart) |=> (tout_valid && $stable(tout_data)));

    // R9
    tout_done_chk: assert property (@(posedge clk) disable iff (rst)
        (tout_valid && tout_ready && !dsp_restart) |=> (dflag && !tout_valid));

    // R11
    skip_either_chk: assert property (@(posedge clk) disable iff (rst)
        (io_valid && io_dev == DSP_DEV && io_op == 4'd5) |-> (skip == (kflag | dflag)));

    // R3
    fetch_start_chk: assert property (@(posedge clk) disable iff (rst)
        kbd_restart |=> (kin_ready && !kflag));

endmodule

bind chario_console chario_console_chk #(
    .ACC_W   (ACC_W),
    .KBD_DEV (KBD_DEV),
    .DSP_DEV (DSP_DEV)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .io_valid   (io_valid),
    .io_dev     (io_dev),
    .io_op      (io_op),
    .acc_in     (acc_in),
    .acc_out    (acc_out),
    .acc_clr    (acc_clr),
    .skip       (skip),
    .kin_valid  (kin_valid),
    .kin_ready  (kin_ready),
    .tout_valid (tout_valid),
    .tout_data  (tout_data),
    .tout_ready (tout_ready),
    .kflag      (kb_flag),
    .dflag      (dp_flag)
);

// File: tb/chario_console_tb.sv
module chario_console_tb;

    localparam int ACC_W = 12;
    localparam int MASK  = (1 << ACC_W) - 1;

    logic             clk = 1'b0;
    logic             rst;
    logic             io_valid;
    logic [7:0]       io_dev;
    logic [3:0]       io_op;
    logic [ACC_W-1:0] acc_in;
    logic [ACC_W-1:0] acc_out;
    logic             acc_clr;
    logic             skip;
    logic             kin_valid;
    logic [7:0]       kin_data;
    logic             kin_ready;
    logic             tout_valid;
    logic [7:0]       tout_data;
    logic             tout_ready;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    // behavioural reference state
    int m_kflag, m_kbusy, m_kcode;
    int m_dflag, m_dbusy, m_dcode;

    always #5 clk = ~clk;

    chario_console #(.ACC_W(ACC_W)) u_dut (
        .clk(clk), .rst(rst), .io_valid(io_valid), .io_dev(io_dev), .io_op(io_op),
        .acc_in(acc_in), .acc_out(acc_out), .acc_clr(acc_clr), .skip(skip),
        .kin_valid(kin_valid), .kin_data(kin_data), .kin_ready(kin_ready),
        .tout_valid(tout_valid), .tout_data(tout_data), .tout_ready(tout_ready)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input int dev, input int op, input int acc,
                        input bit kv, input int kd, input bit tr, input string tag);
        int e_acc, e_skip, e_clr, kview, khs, dhs, nf;
        @(negedge clk);
        io_valid   = v;
        io_dev     = 8'(dev);
        io_op      = 4'(op);
        acc_in     = ACC_W'(acc);
        kin_valid  = kv;
        kin_data   = 8'(kd);
        tout_ready = tr;
        kview  = 'h80 | m_kcode;
        e_acc  = acc & MASK;
        e_skip = 0;
        e_clr  = 0;
        if (v && dev == 3) begin
            if (op == 1) e_skip = m_kflag;
            if (op == 2) begin e_acc = 0; e_clr = 1; end
            if (op == 4) e_acc = (acc | kview) & MASK;
            if (op == 6) begin e_acc = kview; e_clr = 1; end
        end
        if (v && dev == 4) begin
            if (op == 1) e_skip = m_dflag;
            if (op == 5) e_skip = (m_dflag | m_kflag);
        end
        #4;
        check(tag, "acc_out",    int'(acc_out),    e_acc);
        check(tag, "skip",       int'(skip),       e_skip);
        check(tag, "acc_clr",    int'(acc_clr),    e_clr);
        check(tag, "kin_ready",  int'(kin_ready),  m_kbusy);
        check(tag, "tout_valid", int'(tout_valid), m_dbusy);
        check(tag, "tout_data",  int'(tout_data),  m_dcode);
        @(posedge clk);
        khs = m_kbusy && kv;
        dhs = m_dbusy && tr;
        // keyboard update
        nf = m_kflag;
        if (v && dev == 3 && op == 0) nf = 0;
        if (khs) begin nf = 1; m_kcode = kd & 'h7f; m_kbusy = 0; end
        if (v && dev == 3 && (op == 2 || op == 6)) begin nf = 0; m_kbusy = 1; end
        m_kflag = nf;
        // display update
        nf = m_dflag;
        if (v && dev == 4 && op == 0) nf = 1;
        if (v && dev == 4 && op == 2) nf = 0;
        if (dhs) begin nf = 1; m_dbusy = 0; end
        if (v && dev == 4 && (op == 4 || op == 6)) begin m_dbusy = 1; m_dcode = acc & 'h7f; end
        if (v && dev == 4 && op == 6) nf = 0;
        m_dflag = nf;
    endtask

    task automatic idle(input bit kv, input int kd, input bit tr, input string tag);
        step(0, 0, 0, 'h3c3, kv, kd, tr, tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        m_kflag = 0; m_kbusy = 0; m_kcode = 0;
        m_dflag = 0; m_dbusy = 0; m_dcode = 0;
        rst = 1; io_valid = 0; io_dev = 0; io_op = 0; acc_in = 0;
        kin_valid = 0; kin_data = 0; tout_ready = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #4;
        check("R13", "kin_ready",  int'(kin_ready), 0);
        check("R13", "tout_valid", int'(tout_valid), 0);
        check("R13", "tout_data",  int'(tout_data), 0);
        step(1, 3, 4, 'h000, 0, 0, 0, "R13");
        step(1, 3, 1, 'h000, 0, 0, 0, "R13");
        step(1, 4, 1, 'h000, 0, 0, 0, "R13");

        // unknown device codes and ops
        step(1, 5, 2, 'h5a5, 0, 0, 0, "R1");
        step(1, 3, 3, 'h5a5, 0, 0, 0, "R1");
        step(1, 4, 3, 'h5a5, 0, 0, 0, "R1");
        step(1, 4, 7, 'h5a5, 0, 0, 0, "R1");
        step(0, 3, 2, 'h123, 0, 0, 0, "R1");
        step(0, 4, 0, 'h123, 0, 0, 0, "R1");
        step(1, 4, 1, 'h000, 0, 0, 0, "R1");
        step(1, 3, 1, 'h000, 0, 0, 0, "R1");

        // keyboard fetch and reads
        step(1, 3, 2, 'hfff, 0, 0, 0, "R3");
        idle(0, 0, 0, "R3");
        step(1, 3, 1, 0, 0, 0, 0, "R3");
        idle(1, 'h41, 0, "R4");
        idle(1, 'h55, 0, "R4");
        step(1, 3, 1, 0, 0, 0, 0, "R4");
        step(1, 3, 4, 'h700, 0, 0, 0, "R5");
        step(1, 3, 1, 0, 0, 0, 0, "R5");
        step(1, 3, 6, 'habc, 0, 0, 0, "R6");
        step(1, 3, 1, 0, 0, 0, 0, "R6");
        idle(1, 'h35, 0, "R7");
        step(1, 3, 4, 'h000, 0, 0, 0, "R7");
        step(1, 3, 0, 0, 0, 0, 0, "R2");
        step(1, 3, 1, 0, 0, 0, 0, "R2");
        step(1, 3, 6, 'h000, 0, 0, 0, "R6");
        idle(1, 'hc2, 0, "R7");
        step(1, 3, 6, 'hfff, 0, 0, 0, "R7");

        // display flag ops
        step(1, 4, 1, 0, 0, 0, 0, "R8");
        step(1, 4, 0, 0, 0, 0, 0, "R8");
        step(1, 4, 1, 0, 0, 0, 0, "R8");
        step(1, 4, 2, 0, 0, 0, 0, "R8");
        step(1, 4, 1, 0, 0, 0, 0, "R8");

        // display sends
        step(1, 4, 4, 'hfc8, 0, 0, 0, "R9");
        idle(0, 0, 0, "R9");
        step(1, 4, 5, 0, 0, 0, 0, "R11");
        idle(0, 0, 1, "R9");
        step(1, 4, 1, 0, 0, 0, 0, "R9");
        step(1, 4, 5, 0, 0, 0, 0, "R11");
        step(1, 4, 6, 'h0d5, 0, 0, 0, "R10");
        step(1, 4, 1, 0, 0, 0, 0, "R10");
        idle(0, 0, 1, "R10");
        step(1, 4, 1, 0, 0, 0, 0, "R10");
        step(1, 4, 2, 0, 0, 0, 0, "R11");
        step(1, 4, 5, 0, 0, 0, 0, "R11");
        step(1, 3, 2, 0, 0, 0, 0, "R11");
        step(1, 4, 5, 0, 0, 0, 0, "R11");

        // same-cycle overlaps
        step(1, 3, 2, 0, 1, 'h22, 0, "R12");
        step(1, 3, 1, 0, 0, 0, 0, "R12");
        step(1, 3, 0, 0, 1, 'h23, 0, "R12");
        step(1, 3, 1, 0, 0, 0, 0, "R12");
        step(1, 4, 4, 'h061, 0, 0, 0, "R12");
        step(1, 4, 2, 0, 0, 0, 1, "R12");
        step(1, 4, 1, 0, 0, 0, 0, "R12");
        step(1, 4, 4, 'h062, 0, 0, 0, "R12");
        step(1, 4, 6, 'h063, 0, 0, 1, "R12");
        step(1, 4, 1, 0, 0, 0, 0, "R12");
        idle(0, 0, 1, "R12");

        // long mixed run
        for (int i = 0; i < 3000; i++) begin
            int dv, r;
            r  = int'($urandom_range(0, 9));
            dv = (r < 4) ? 3 : (r < 8) ? 4 : 5;
            step(1'($urandom_range(0, 3) != 0), dv, int'($urandom_range(0, 7)),
                 int'($urandom_range(0, MASK)), 1'($urandom_range(0, 1)),
                 int'($urandom_range(0, 255)), 1'($urandom_range(0, 1)), "R12");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule